// File: doc/BRIEF.md
# Byte-Addressed Register Bank Behind a Serial Slave Port

This block is a four-wire serial slave that gives an external master access to a bank of 16-bit registers. Every register has two byte addresses. A write frame changes one byte. A read frame names either byte address of a register, and the whole 16-bit value comes back on the data output during the next frame. While a command's result is shifting out, the master can send a new command in the same frame. A run of reads therefore costs only one frame more than the number of reads.

The chip-select, serial clock and data input pass through two-flop synchronizers into the system clock `clk`, and all decoding runs in that domain. The serial clock idles high. Data in is sampled on rising serial clock edges, and the output bit changes on falling edges, MSB first. The output has a separate enable for an external tristate buffer. The top `NUM_RO` registers are read-only. The fabric loads them every system clock cycle through `ro_value`. The contents of all registers are visible to the fabric on `reg_q`.

Top module: `spi_regbank_slave`

## Requirements
- R1: A frame is 16 serial clock rising edges, MSB first: bit 15 is the write flag (1 = write, 0 = read), bit 14 must be 0, bits 13..8 are the byte address and bits 7..0 are the data. A write to an even address changes only bits 7..0 of register address/2. A write to an odd address changes only bits 15..8.
- R2: A read frame to either byte address of a register returns all 16 bits on `spi_miso` during the next frame, MSB first. Its low 8 data bits have no effect.
- R3: The first frame after chip-select falls, and the frame after any write, shifts out 0x0000.
- R4: Addresses at or above 2*NUM_REGS are unmapped. Reads from them return 0x0000, and writes to them change no register.
- R5: Register indices NUM_REGS-NUM_RO and up take `ro_value` (16 bits each, lowest slice first) one clock later. Writes to them have no effect.
- R6: While chip-select is high, `spi_miso_oe` and `spi_miso` are low, and serial clock and data activity changes no register.
- R7: When chip-select rises before a frame's 16th bit, the partial frame is dropped without any register update. The next chip-select-low period starts a fresh frame.
- R8: A frame with bit 14 set is ignored: no register changes, and the next frame shifts out 0x0000.
- R9: After reset, all writable registers read 0 and the output enable is low.
- R10: One chip-select-low period can hold any number of back-to-back frames, and each one is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the master, idles high |
| spi_mosi | input | 1 | Serial command/data input |
| spi_miso | output | 1 | Serial data output, low when not enabled |
| spi_miso_oe | output | 1 | Output enable for the external tristate buffer |
| ro_value | input | 16*NUM_RO | Values loaded into the read-only registers |
| reg_q | output | 16*NUM_REGS | Contents of all registers, register i at bits 16*i+15..16*i |

## Verification
A register write lands about four system clocks after the 16th rising serial clock edge, and a new output bit shows about four clocks after each falling edge. The bench holds each serial clock phase for eight system clocks. It samples `spi_miso` at the end of the low phase, just before raising the clock. Register contents and the output enable are read only after at least one full half period has passed, so every result has settled before it is sampled. The checker waits a counted number of clocks after chip-select rises before it requires quiet outputs and stable registers, to cover the synchronizer delay.

// File: rtl/spi_rb_pkg.sv
`timescale 1ns/1ps
package spi_rb_pkg;
    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 6;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(FRAME_W);

    typedef struct packed {
        logic              wr;     // 1 = write, 0 = read
        logic              rsvd;   // must be zero for a valid frame
        logic [ADDR_W-1:0] addr;   // byte address
        logic [BYTE_W-1:0] data;   // write data, ignored on reads
    } cmd_t;

    function automatic logic addr_mapped(input logic [ADDR_W-1:0] a, input int n_regs);
        return int'(a) < 2 * n_regs;
    endfunction

    function automatic logic cmd_ok(input cmd_t c);
        return !c.rsvd;
    endfunction
endpackage

// File: rtl/spi_rb_sync.sv
`timescale 1ns/1ps
module spi_rb_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_rb_frame_rx.sv
`timescale 1ns/1ps
module spi_rb_frame_rx
    import spi_rb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_s,     // synchronized, active high = idle
    input  logic             sclk_s,
    input  logic             mosi_s,
    output logic             frame_valid,
    output cmd_t             frame,
    output logic             sclk_fall,
    output logic             cs_fall,
    output logic [CNT_W-1:0] bit_cnt
);
    logic             sclk_prev;
    logic             cs_prev;
    logic             sclk_rise;
    logic [FRAME_W-1:0] shreg;

    assign sclk_rise = sclk_s & ~sclk_prev & ~cs_s;
    assign sclk_fall = ~sclk_s & sclk_prev & ~cs_s;
    assign cs_fall   = cs_prev & ~cs_s;
    assign frame     = cmd_t'(shreg);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev   <= 1'b1;
            cs_prev     <= 1'b1;
            shreg       <= '0;
            bit_cnt     <= '0;
            frame_valid <= 1'b0;
        end else begin
            sclk_prev   <= sclk_s;
            cs_prev     <= cs_s;
            frame_valid <= 1'b0;
            if (cs_s) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                shreg <= {shreg[FRAME_W-2:0], mosi_s};
                if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
                    bit_cnt     <= '0;
                    frame_valid <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_rb_regs.sv
`timescale 1ns/1ps
module spi_rb_regs
    import spi_rb_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int NUM_RO   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [BYTE_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [FRAME_W-1:0]        rd_data,
    input  logic [NUM_RO*FRAME_W-1:0] ro_value,
    output logic [NUM_REGS*FRAME_W-1:0] reg_q
);
    localparam int NUM_W = NUM_REGS - NUM_RO;
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic             wr_hit;
    logic [IDX_W-1:0] wr_sel;
    logic [IDX_W-1:0] rd_sel;

    assign wr_hit = wr_en && addr_mapped(wr_addr, NUM_REGS);
    assign wr_sel = wr_addr[IDX_W:1];
    assign rd_sel = rd_addr[IDX_W:1];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [FRAME_W-1:0] q;
        if (i < NUM_W) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_hit && int'(wr_sel) == i) begin
                    if (wr_addr[0]) q[FRAME_W-1:BYTE_W] <= wr_data;
                    else            q[BYTE_W-1:0]       <= wr_data;
                end
            end
        end else begin : g_ro
            always_ff @(posedge clk) begin
                q <= ro_value[(i - NUM_W)*FRAME_W +: FRAME_W];
            end
        end
        assign reg_q[i*FRAME_W +: FRAME_W] = q;
    end

    assign rd_data = addr_mapped(rd_addr, NUM_REGS) ? reg_q[rd_sel*FRAME_W +: FRAME_W] : '0;
endmodule

// File: rtl/spi_rb_tx.sv
`timescale 1ns/1ps
module spi_rb_tx
    import spi_rb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               shift,
    input  logic [CNT_W-1:0]   bit_cnt,
    output logic               miso_q
);
    logic [FRAME_W-1:0] word;

    always_ff @(posedge clk) begin
        if (rst) begin
            word   <= '0;
            miso_q <= 1'b0;
        end else if (clear) begin
            word   <= '0;
            miso_q <= 1'b0;
        end else begin
            if (load)  word   <= load_word;
            if (shift) miso_q <= word[CNT_W'(FRAME_W - 1) - bit_cnt];
        end
    end
endmodule

// File: rtl/spi_regbank_slave.sv
`timescale 1ns/1ps
module spi_regbank_slave
    import spi_rb_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int NUM_RO   = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        spi_cs_n,
    input  logic                        spi_sclk,
    input  logic                        spi_mosi,
    output logic                        spi_miso,
    output logic                        spi_miso_oe,
    input  logic [NUM_RO*FRAME_W-1:0]   ro_value,
    output logic [NUM_REGS*FRAME_W-1:0] reg_q
);
    logic [2:0]         pins_s;
    logic               cs_s, sclk_s, mosi_s;
    logic               frame_valid, sclk_fall, cs_fall;
    cmd_t               frame;
    logic [CNT_W-1:0]   bit_cnt;
    logic               accept, wr_en;
    logic [FRAME_W-1:0] rd_data, resp_word;
    logic               miso_q;

    spi_rb_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_cs_n, spi_sclk, spi_mosi}),
        .q   (pins_s)
    );
    assign {cs_s, sclk_s, mosi_s} = pins_s;

    spi_rb_frame_rx u_rx (
        .clk         (clk),
        .rst         (rst),
        .cs_s        (cs_s),
        .sclk_s      (sclk_s),
        .mosi_s      (mosi_s),
        .frame_valid (frame_valid),
        .frame       (frame),
        .sclk_fall   (sclk_fall),
        .cs_fall     (cs_fall),
        .bit_cnt     (bit_cnt)
    );

    assign accept    = frame_valid && cmd_ok(frame);
    assign wr_en     = accept && frame.wr;
    assign resp_word = (accept && !frame.wr) ? rd_data : '0;

    spi_rb_regs #(.NUM_REGS(NUM_REGS), .NUM_RO(NUM_RO)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (frame.addr),
        .wr_data  (frame.data),
        .rd_addr  (frame.addr),
        .rd_data  (rd_data),
        .ro_value (ro_value),
        .reg_q    (reg_q)
    );

    spi_rb_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .clear     (cs_fall),
        .load      (frame_valid),
        .load_word (resp_word),
        .shift     (sclk_fall),
        .bit_cnt   (bit_cnt),
        .miso_q    (miso_q)
    );

    assign spi_miso_oe = ~cs_s;
    assign spi_miso    = spi_miso_oe & miso_q;
endmodule

// File: rtl/spi_regbank_checker.sv
`timescale 1ns/1ps
module spi_regbank_checker #(
    parameter int NUM_REGS = 8,
    parameter int NUM_RO   = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     spi_cs_n,
    input logic                     spi_miso,
    input logic                     spi_miso_oe,
    input logic [NUM_RO*16-1:0]     ro_value,
    input logic [NUM_REGS*16-1:0]   reg_q
);
    localparam int WBITS = (NUM_REGS - NUM_RO) * 16;
    logic [2:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst || !spi_cs_n) idle_cnt <= '0;
        else if (idle_cnt != 3'd7) idle_cnt <= idle_cnt + 1'b1;
    end

    assert_oe_off_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt >= 3'd3) |-> !spi_miso_oe);

    assert_miso_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !spi_miso_oe |-> !spi_miso);

    assert_regs_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt >= 3'd6) |-> $stable(reg_q[WBITS-1:0]));

    assert_ro_follows_input_R5: assert property (@(posedge clk) disable iff (rst)
        reg_q[NUM_REGS*16-1:WBITS] == $past(ro_value));

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (reg_q[WBITS-1:0] == '0 && !spi_miso_oe));
endmodule

bind spi_regbank_slave spi_regbank_checker #(.NUM_REGS(NUM_REGS), .NUM_RO(NUM_RO)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .spi_cs_n    (spi_cs_n),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .ro_value    (ro_value),
    .reg_q       (reg_q)
);

// File: tb/spi_regbank_slave_test.sv
`timescale 1ns/1ps
module spi_regbank_slave_test;
    localparam int NUM_REGS = 8;
    localparam int NUM_RO   = 2;
    localparam int HALF     = 64;   // 8 system clocks per serial clock phase
    localparam int NVEC     = 16;

    // {command, expected DOUT word during that frame}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h8034, 16'h0000},  // R1 write reg0 low; R3 first frame zeros
        {16'h8112, 16'h0000},  // R1 write reg0 high; R3 after write
        {16'h0000, 16'h0000},  // R2 read addr0
        {16'h01A5, 16'h1234},  // R2 read addr1, junk data byte
        {16'h84AB, 16'h1234},  // R1 write reg2 low
        {16'h05FF, 16'h0000},  // R2 read reg2 via odd address
        {16'h0C00, 16'h00AB},  // R5 read RO reg6
        {16'h8C55, 16'hC0DE},  // R5 write to RO ignored
        {16'h1400, 16'h0000},  // R4 read unmapped
        {16'h0D00, 16'h0000},  // R4 unmapped read returned zero
        {16'h8277, 16'hC0DE},  // R5 RO unchanged
        {16'h0300, 16'h0000},  // R1 read reg1
        {16'h0000, 16'h0077},  // R1 low byte only
        {16'h9499, 16'h1234},  // R4 write unmapped
        {16'h0F00, 16'h0000},  // R3 after write
        {16'h0000, 16'hBEEF}   // R10 read reg7 via upper address
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_cs_n = 1'b1, spi_sclk = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;
    logic [NUM_RO*16-1:0]   ro_value = {16'hBEEF, 16'hC0DE};
    logic [NUM_REGS*16-1:0] reg_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    spi_regbank_slave #(.NUM_REGS(NUM_REGS), .NUM_RO(NUM_RO)) uut (
        .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .ro_value(ro_value), .reg_q(reg_q)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
        rx = '0;
        for (int b = 15; b > 15 - nbits; b--) begin
            spi_sclk = 1'b0;
            spi_mosi = tx[b];
            #HALF;
            rx[b] = spi_miso;
            spi_sclk = 1'b1;
            #HALF;
        end
    endtask

    task automatic cs_begin;
        spi_cs_n = 1'b0;
        #HALF;
    endtask

    task automatic cs_end;
        #HALF;
        spi_cs_n = 1'b1;
        #(2*HALF);
    endtask

    function automatic logic [15:0] reg_of(input int i);
        return reg_q[i*16 +: 16];
    endfunction

    initial begin
        #(150000*8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] rx;
        @(negedge clk);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R9 reset state
        check("R9 oe", {15'd0, spi_miso_oe}, 16'h0000);
        for (int i = 0; i < NUM_REGS - NUM_RO; i++) check("R9 reg", reg_of(i), 16'h0000);
        check("R5 ro6", reg_of(6), 16'hC0DE);

        // R10 vector table in one chip-select period
        cs_begin();
        check("R6 oe during cs low", {15'd0, spi_miso_oe}, 16'h0001);
        for (int v = 0; v < NVEC; v++) begin
            xfer(VEC[v][31:16], 16, rx);
            check($sformatf("R10 vector %0d", v), rx, VEC[v][15:0]);
        end
        cs_end();

        check("R1 reg0", reg_of(0), 16'h1234);
        check("R1 reg1", reg_of(1), 16'h0077);
        check("R1 reg2", reg_of(2), 16'h00AB);
        check("R4 reg3", reg_of(3), 16'h0000);
        check("R4 reg5", reg_of(5), 16'h0000);
        check("R5 reg7", reg_of(7), 16'hBEEF);
        check("R6 oe idle", {15'd0, spi_miso_oe}, 16'h0000);

        // R3: pending read from previous period does not leak; R8 rsvd bit
        cs_begin();
        xfer(16'hC0EE, 16, rx); check("R3 first frame zeros", rx, 16'h0000);
        xfer(16'h4000, 16, rx); check("R8 after ignored write", rx, 16'h0000);
        xfer(16'h0000, 16, rx); check("R8 ignored read gives zeros", rx, 16'h0000);
        xfer(16'h0000, 16, rx); check("R8 reg0 kept", rx, 16'h1234);
        cs_end();
        check("R8 reg0 port", reg_of(0), 16'h1234);

        // R7 partial frame dropped
        cs_begin();
        xfer(16'h8066, 8, rx);
        cs_end();
        check("R7 reg0 after partial", reg_of(0), 16'h1234);
        cs_begin();
        xfer(16'h0100, 16, rx); check("R7 fresh frame", rx, 16'h0000);
        xfer(16'h0000, 16, rx); check("R7 counter realigned", rx, 16'h1234);
        cs_end();

        // R6 activity with chip select high
        xfer(16'h8011, 16, rx);
        check("R6 miso idle", rx, 16'h0000);
        check("R6 oe idle", {15'd0, spi_miso_oe}, 16'h0000);
        #(2*HALF);
        check("R6 reg0 untouched", reg_of(0), 16'h1234);

        // R5 fabric update of read-only register
        ro_value = {16'h5A5A, 16'h0F0F};
        #(2*HALF);
        check("R5 ro6 update", reg_of(6), 16'h0F0F);
        cs_begin();
        xfer(16'h0E00, 16, rx);
        xfer(16'h0000, 16, rx); check("R5 ro7 readback", rx, 16'h5A5A);
        cs_end();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule